// File: doc/BRIEF.md
# Receive Address Filter

This block decides, for each incoming frame, whether the frame is kept or dropped, using only the frame's 48-bit destination address. The receive path sends the destination bytes into the filter one at a time, in wire order, with a valid strobe. A separate marker flags the first byte. While the bytes stream in, the filter accumulates an Ethernet CRC-32 over them. One clock after the sixth byte it raises a single-cycle decision strobe. With that strobe it gives an accept flag, a reason code and the multicast hash bucket it derived.

The configuration is a static set of inputs:
- a 48-bit station address;
- a 64-entry multicast hash table, one bit per bucket;
- three mode bits: promiscuous, accept every group address, and accept hashed group addresses.

The filter keeps the last decision on its outputs until the next one, so a consumer may latch the decision at the strobe or later. Frame CRC checking, buffering and DMA are outside this block.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_vld`, `dec_accept`, `dec_reason` and `dec_bucket` are all zero.
- R2: `dec_vld` is high for exactly one cycle: the cycle after the clock edge that samples the sixth byte of an address. The byte marked first counts as byte one, and cycles with `rx_byte_vld` low do not count. Between decisions, `dec_accept`, `dec_reason` and `dec_bucket` hold their last values.
- R3: Byte order. The first byte on the wire is compared with `sta_addr[47:40]` and the sixth with `sta_addr[7:0]`. A unicast match is accepted with reason 3 (station).
- R4: A destination is a group address when bit 0 of its first byte is 1. A unicast destination that does not equal `sta_addr` is rejected with reason 6 (unicast reject), unless promiscuous mode is on.
- R5: With `cfg_promisc` set, every address is accepted with reason 1. This mode has the highest priority.
- R6: The all-ones broadcast address is always accepted with reason 2, whatever the mode bits are (promiscuous excepted).
- R7: With `cfg_all_grp` set, any non-broadcast group address is accepted with reason 4, without a table lookup.
- R8: With only `cfg_hash_grp` set, a non-broadcast group address is accepted with reason 5 when `mc_hash[bucket]` is 1. Otherwise it is rejected with reason 7.
- R9: The bucket is CRC bits 31:26 and is reported on `dec_bucket` with every decision. The CRC is computed as follows:
  - reflected polynomial 0xEDB88320;
  - register preset to all ones;
  - each byte fed least significant bit first;
  - no final inversion.
- R10: A non-broadcast group address that no mode accepts is rejected with reason 7 (group reject). `dec_accept` is 1 exactly for reasons 1 to 5.
- R11: Bytes after the sixth are ignored until the next byte marked first. A byte marked first in the middle of an address restarts the address from that byte.
- R12: Bytes received after reset, before any byte marked first, are ignored and produce no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte_vld | input | 1 | A destination byte is present |
| rx_byte_first | input | 1 | The present byte is the first of an address |
| rx_byte | input | 8 | Destination byte in wire order |
| sta_addr | input | 48 | Station address, first wire byte in bits 47:40 |
| mc_hash | input | 64 | Multicast hash table, bit n = bucket n |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_all_grp | input | 1 | Accept every group address |
| cfg_hash_grp | input | 1 | Accept group addresses whose bucket bit is set |
| dec_vld | output | 1 | Single-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | Reason code (0 none, 1 promiscuous, 2 broadcast, 3 station, 4 all-group, 5 hash hit, 6 unicast reject, 7 group reject) |
| dec_bucket | output | 6 | Hash bucket of the last decided address |

## Verification
The only result with a deadline is the decision: it is due exactly one clock after the edge that samples the sixth valid byte. Every other byte, including idle gaps, extra bytes and bytes before any first marker, must leave `dec_vld` low.

The bench drives each byte on the falling edge. At every following falling edge it checks that no strobe has appeared early. At the falling edge after the sixth byte it checks the strobe and compares accept, reason and bucket with values from its own CRC and priority model. At the next falling edge it checks that the strobe has dropped and the fields are held.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int ADDR_BYTES  = 6;
    localparam int ADDR_W      = ADDR_BYTES * 8;
    localparam int CNT_W       = $clog2(ADDR_BYTES + 1);
    localparam int HASH_IDX_W  = 6;
    localparam int HASH_W      = 1 << HASH_IDX_W;
    localparam int CRC_W       = 32;
    localparam logic [CRC_W-1:0] CRC_POLY   = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_PRESET = '1;

    typedef enum logic [2:0] {
        RSN_NONE    = 3'd0,
        RSN_PROMISC = 3'd1,
        RSN_BCAST   = 3'd2,
        RSN_STATION = 3'd3,
        RSN_ALLGRP  = 3'd4,
        RSN_HASH    = 3'd5,
        RSN_REJ_UNI = 3'd6,
        RSN_REJ_GRP = 3'd7
    } reason_e;

    // Advance a reflected CRC register by one byte, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                   input logic [7:0] b);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/rxf_addr_cap.sv
module rxf_addr_cap
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              byte_first,
    input  logic [7:0]        byte_in,
    output logic              take,
    output logic              restart,
    output logic              done,
    output logic [ADDR_W-1:0] addr_nxt
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;   // 0: idle, 1..ADDR_BYTES: bytes gathered
        logic [ADDR_W-1:0] addr;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d   = cap_q;
        restart = byte_vld && byte_first;
        take    = restart ||
                  (byte_vld && (cap_q.cnt != '0) && (cap_q.cnt < CNT_W'(ADDR_BYTES)));
        if (restart) begin
            cap_d.cnt  = CNT_W'(1);
            cap_d.addr = {{(ADDR_W-8){1'b0}}, byte_in};
        end else if (take) begin
            cap_d.cnt  = cap_q.cnt + CNT_W'(1);
            cap_d.addr = {cap_q.addr[ADDR_W-9:0], byte_in};
        end
        done     = take && (cap_d.cnt == CNT_W'(ADDR_BYTES));
        addr_nxt = cap_d.addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.cnt <= CNT_W'(ADDR_BYTES));

    assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_first) |=> (cap_q.cnt == CNT_W'(1)));

    assert_no_first_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.cnt == '0 && !(byte_vld && byte_first)) |=> (cap_q.cnt == '0));
endmodule

// File: rtl/rxf_crc_acc.sv
module rxf_crc_acc
    import rxf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic                  restart,
    input  logic [7:0]            byte_in,
    output logic [HASH_IDX_W-1:0] bucket_nxt
);
    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_t;

    crc_t crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (take)
            crc_d.crc = crc_byte(restart ? CRC_PRESET : crc_q.crc, byte_in);
        bucket_nxt = crc_d.crc[CRC_W-1 -: HASH_IDX_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '{crc: CRC_PRESET};
        else        crc_q <= crc_d;
    end

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(crc_q.crc));
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    input  logic [HASH_IDX_W-1:0] bucket,
    input  logic [ADDR_W-1:0]     sta_addr,
    input  logic [HASH_W-1:0]     mc_hash,
    input  logic                  cfg_promisc,
    input  logic                  cfg_all_grp,
    input  logic                  cfg_hash_grp,
    output logic                  accept,
    output reason_e               reason
);
    logic is_group, is_bcast, sta_hit, hash_hit;

    always_comb begin
        is_group = addr[ADDR_W-8];
        is_bcast = &addr;
        sta_hit  = (addr == sta_addr);
        hash_hit = mc_hash[bucket];

        if (cfg_promisc)                   reason = RSN_PROMISC;
        else if (is_bcast)                 reason = RSN_BCAST;
        else if (sta_hit)                  reason = RSN_STATION;
        else if (!is_group)                reason = RSN_REJ_UNI;
        else if (cfg_all_grp)              reason = RSN_ALLGRP;
        else if (cfg_hash_grp && hash_hit) reason = RSN_HASH;
        else                               reason = RSN_REJ_GRP;

        accept = (reason != RSN_REJ_UNI) && (reason != RSN_REJ_GRP);
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_byte_vld,
    input  logic        rx_byte_first,
    input  logic [7:0]  rx_byte,
    input  logic [47:0] sta_addr,
    input  logic [63:0] mc_hash,
    input  logic        cfg_promisc,
    input  logic        cfg_all_grp,
    input  logic        cfg_hash_grp,
    output logic        dec_vld,
    output logic        dec_accept,
    output logic [2:0]  dec_reason,
    output logic [5:0]  dec_bucket
);
    typedef struct packed {
        logic                  vld;
        logic                  accept;
        reason_e               reason;
        logic [HASH_IDX_W-1:0] bucket;
    } dec_t;

    logic                  take, restart, done;
    logic [ADDR_W-1:0]     addr_nxt;
    logic [HASH_IDX_W-1:0] bucket_nxt;
    logic                  acc_c;
    reason_e               rsn_c;
    dec_t                  dec_d, dec_q;

    rxf_addr_cap u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (rx_byte_vld),
        .byte_first (rx_byte_first),
        .byte_in    (rx_byte),
        .take       (take),
        .restart    (restart),
        .done       (done),
        .addr_nxt   (addr_nxt)
    );

    rxf_crc_acc u_crc (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .restart    (restart),
        .byte_in    (rx_byte),
        .bucket_nxt (bucket_nxt)
    );

    rxf_decide u_dec (
        .addr         (addr_nxt),
        .bucket       (bucket_nxt),
        .sta_addr     (sta_addr),
        .mc_hash      (mc_hash),
        .cfg_promisc  (cfg_promisc),
        .cfg_all_grp  (cfg_all_grp),
        .cfg_hash_grp (cfg_hash_grp),
        .accept       (acc_c),
        .reason       (rsn_c)
    );

    always_comb begin
        dec_d     = dec_q;
        dec_d.vld = done;
        if (done) begin
            dec_d.accept = acc_c;
            dec_d.reason = rsn_c;
            dec_d.bucket = bucket_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '{vld: 1'b0, accept: 1'b0, reason: RSN_NONE, bucket: '0};
        else        dec_q <= dec_d;
    end

    assign dec_vld    = dec_q.vld;
    assign dec_accept = dec_q.accept;
    assign dec_reason = dec_q.reason;
    assign dec_bucket = dec_q.bucket;

    assert_vld_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> $past(rx_byte_vld));

    assert_vld_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |=> !dec_vld);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld |-> ($stable(dec_reason) && $stable(dec_accept) && $stable(dec_bucket)));

    assert_promisc_accepts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && $past(cfg_promisc)) |-> (dec_accept && dec_reason == 3'd1));

    assert_hash_bit_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_reason == 3'd5) |->
            ((($past(mc_hash) >> dec_bucket) & 64'd1) != 64'd0));

    assert_reject_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_reason[2:1] == 2'b11) |-> !dec_accept);
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_byte_vld = 1'b0;
    logic        rx_byte_first = 1'b0;
    logic [7:0]  rx_byte = 8'd0;
    logic [47:0] sta_addr = 48'h0;
    logic [63:0] mc_hash = 64'h0;
    logic        cfg_promisc = 1'b0;
    logic        cfg_all_grp = 1'b0;
    logic        cfg_hash_grp = 1'b0;
    logic        dec_vld, dec_accept;
    logic [2:0]  dec_reason;
    logic [5:0]  dec_bucket;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    rx_addr_filter uut (.*);

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            logic bitv, fb;
            bitv = a[47 - 8*(k/8) - 7 + (k%8)];
            fb = c[0] ^ bitv;
            c = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB8_8320;
        end
        return c;
    endfunction

    function automatic logic [2:0] ref_reason(input logic [47:0] a);
        logic [5:0] b = ref_crc(a)[31:26];
        if (cfg_promisc)                  return 3'd1;
        if (a == 48'hFFFF_FFFF_FFFF)      return 3'd2;
        if (a == sta_addr)                return 3'd3;
        if (!a[40])                       return 3'd6;
        if (cfg_all_grp)                  return 3'd4;
        if (cfg_hash_grp && mc_hash[b])   return 3'd5;
        return 3'd7;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            rx_byte_vld = 1'b0;
            rx_byte_first = 1'b0;
            @(negedge clk);
        end
    endtask

    // Send one address; optional gaps between bytes; check timing and decision.
    task automatic send_addr(input logic [47:0] a, input bit gaps, input string tag);
        logic [2:0] er = ref_reason(a);
        logic [5:0] eb = ref_crc(a)[31:26];
        for (int i = 0; i < 6; i++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                rx_byte_vld = 1'b0;
                @(negedge clk);
                chk({"R2 no strobe in gap ", tag}, dec_vld, 0);
            end
            rx_byte_vld   = 1'b1;
            rx_byte_first = (i == 0);
            rx_byte       = a[47 - 8*i -: 8];
            @(negedge clk);
            if (i < 5) chk({"R2 early strobe ", tag}, dec_vld, 0);
        end
        rx_byte_vld = 1'b0;
        rx_byte_first = 1'b0;
        chk({"R2 strobe ", tag}, dec_vld, 1);
        chk({"R3-R10 reason ", tag}, dec_reason, er);
        chk({"R10 accept ", tag}, dec_accept, (er >= 3'd1 && er <= 3'd5));
        chk({"R9 bucket ", tag}, dec_bucket, eb);
        @(negedge clk);
        chk({"R2 single pulse ", tag}, dec_vld, 0);
        chk({"R2 hold reason ", tag}, dec_reason, er);
    endtask

    task automatic set_mode(input bit p, input bit ag, input bit hg);
        cfg_promisc = p; cfg_all_grp = ag; cfg_hash_grp = hg;
    endtask

    initial begin
        logic [47:0] a;
        void'($urandom(32'd20240611));
        sta_addr = 48'h02A4_5C11_7E3B;   // unicast
        mc_hash  = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 vld", dec_vld, 0);
        chk("R1 accept", dec_accept, 0);
        chk("R1 reason", dec_reason, 0);
        chk("R1 bucket", dec_bucket, 0);
        rst_n = 1'b1;

        // R12 bytes before any first marker
        for (int i = 0; i < 8; i++) begin
            rx_byte_vld = 1'b1; rx_byte = 8'(i * 37);
            @(negedge clk);
            chk("R12 no decision before first", dec_vld, 0);
        end
        idle(2);
        chk("R12 reason untouched", dec_reason, 0);

        // R3 station match, R4 unicast reject
        set_mode(0, 0, 0);
        send_addr(sta_addr, 0, "R3 station");
        send_addr(sta_addr ^ 48'h0000_0000_0001, 0, "R4 unicast miss");
        // R6 broadcast with no modes
        send_addr(48'hFFFF_FFFF_FFFF, 0, "R6 broadcast");
        // R10 group with no modes
        send_addr(48'h0100_5E00_0001, 0, "R10 group reject");
        // R7 all-group
        set_mode(0, 1, 0);
        send_addr(48'h0100_5E00_0001, 0, "R7 all group");
        // R5 promiscuous over unicast miss
        set_mode(1, 0, 0);
        send_addr(48'h0A0B_0C0D_0E0F, 0, "R5 promisc");
        // R8 hash hit and miss on the same address
        set_mode(0, 0, 1);
        a = 48'h3333_0000_0001;
        mc_hash = 64'h0;
        mc_hash[ref_crc(a)[31:26]] = 1'b1;
        send_addr(a, 0, "R8 hash hit");
        mc_hash = ~mc_hash;
        send_addr(a, 1, "R8 hash miss");

        // R11 extra bytes ignored
        send_addr(sta_addr, 0, "R11 before extra");
        for (int i = 0; i < 4; i++) begin
            rx_byte_vld = 1'b1; rx_byte_first = 1'b0; rx_byte = 8'hFF;
            @(negedge clk);
            chk("R11 extra byte no strobe", dec_vld, 0);
        end
        idle(1);
        chk("R11 extra bytes keep reason", dec_reason, 3'd3);
        // R11 restart mid-address
        for (int i = 0; i < 3; i++) begin
            rx_byte_vld = 1'b1; rx_byte_first = (i == 0); rx_byte = 8'hFF;
            @(negedge clk);
            chk("R11 partial no strobe", dec_vld, 0);
        end
        send_addr(sta_addr, 0, "R11 restart");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int unsigned kind;
            if (n % 8 == 0) begin
                set_mode(($urandom % 6) == 0, ($urandom % 3) == 0, $urandom % 2);
                mc_hash = {$urandom, $urandom};
                sta_addr = {$urandom, 16'($urandom)} & ~48'h0100_0000_0000;
            end
            kind = $urandom % 5;
            a = {$urandom, 16'($urandom)};
            case (kind)
                0: a = sta_addr;
                1: a = 48'hFFFF_FFFF_FFFF;
                2: a[40] = 1'b0;
                default: a[40] = 1'b1;
            endcase
            send_addr(a, $urandom % 2, "random R9");
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule